// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the address and count engine of a single DMA channel. Software loads a block length, a repeat count, a 24-bit source address and a control byte through a byte-wide write port. When the channel is enabled and idle, a trigger pulse starts a block. The block issues one request per data element on a valid/ready interface, and each request carries the current source address. After every accepted element the address moves up by one, moves down by one, or holds, as chosen by a two-bit step field.

A block ends when its element counter runs out. A programmed length of zero gives the longest block the counter allows. In repeat mode each further block needs its own trigger. The element counter reloads from the programmed length, while the source address carries on from where the previous block left it. A finite repeat count runs down once per completed block, and the channel turns itself off after the block that brings it to zero. A repeat count of zero keeps the channel enabled without limit. Software can stop a running block by writing a control byte with the enable bit clear. All other writes are dropped while a block runs.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `enabled`, `req_valid` and `done` are low, the source address is 0, the repeat count is 0 and the programmed block length is 1.
- R2: Write offsets: 0 is control (bit 0 enable, bit 1 repeat mode, bits 3:2 step field). 1 is the block length low byte and 2 is its high byte. 3 is the repeat count. 4, 5 and 6 are source address bytes 0, 1 and 2, with byte 2 the most significant.
- R3: A trigger while enabled and idle makes `req_valid` high from the next cycle. A trigger while disabled or while a block runs is ignored.
- R4: While a block runs, `req_valid` is high and `req_addr` shows the current source address. An element completes in each cycle in which `req_valid` and `req_ready` are both high. `req_addr` holds steady while the request waits.
- R5: After each completed element the address changes according to the step field: 01 adds one, 10 subtracts one, and 00 or 11 leaves it unchanged. The arithmetic wraps modulo 2^24.
- R6: A block completes exactly the programmed number of elements. A programmed length of 0 gives 65535 elements.
- R7: After each completed block the repeat count decrements if it is nonzero. With repeat mode off, the channel disables after one block.
- R8: In repeat mode, the channel disables after the block that takes the repeat count from 1 to 0. With a repeat count of 0 it stays enabled indefinitely. Each block reloads the length, and the address continues from the previous block.
- R9: When the channel disables at the end of a block, `done` is high for exactly one cycle (the cycle after the final handshake), and `enabled` is low from that same cycle.
- R10: Register writes are ignored while a block runs and in the cycle in which a trigger starts a block.
- R11: A control write with bit 0 clear while a block runs aborts it. The abort happens at the first handshake in or after the write cycle: `req_valid` drops in the next cycle, `enabled` clears and `done` pulses. This holds even in repeat mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write byte |
| trig | input | 1 | Block start trigger |
| req_ready | input | 1 | Element request accepted |
| req_valid | output | 1 | Element request pending |
| req_addr | output | 24 | Source address of the pending element |
| enabled | output | 1 | Channel enable state |
| done | output | 1 | One-cycle pulse when the channel disables itself or aborts |

## Verification
Two functions can fall in the same cycle: a software abort and the final handshake of a block. Another collision is a trigger arriving together with a register write. The bench forces the abort write into the cycle where `req_ready` accepts the last element of a repeat-mode block that would otherwise stay enabled. It then expects a single `done` pulse, a cleared enable and no extra element. A trigger issued with a length write in the same cycle must run the previously programmed length, which shows that the start wins and the write is dropped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    // Register offset space of the channel write port
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_LEN_LO = 3'd1;
    localparam logic [REG_AW-1:0] OFS_RPT    = 3'd3;
    localparam logic [REG_AW-1:0] OFS_ADR0   = 3'd4;

    // Address step selection
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_KEEP  = 2'b11
    } step_e;

    // Control byte, low nibble: {step, repeat mode, enable}
    typedef struct packed {
        step_e dir;
        logic  rpt_mode;
        logic  en;
    } ctrl_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;

    function automatic ctrl_t ctrl_from_nibble(input logic [3:0] b);
        ctrl_t c;
        c.en       = b[0];
        c.rpt_mode = b[1];
        c.dir      = step_e'(b[3:2]);
        return c;
    endfunction

    function automatic logic is_offset(input logic [REG_AW-1:0] a, input int ofs);
        return a == REG_AW'(ofs);
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              en_clr,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  blk_len
);
    localparam int LEN_BYTES = CNT_W / 8;
    localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(1);

    logic [7:0] len_b [LEN_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ok && wr_addr == OFS_CTRL) begin
            ctrl <= ctrl_from_nibble(wr_data[3:0]);
        end else if (en_clr) begin
            ctrl.en <= 1'b0;
        end
    end

    for (genvar i = 0; i < LEN_BYTES; i++) begin : g_len
        always_ff @(posedge clk) begin
            if (rst) begin
                len_b[i] <= LEN_RST[8*i +: 8];
            end else if (wr_ok && is_offset(wr_addr, int'(OFS_LEN_LO) + i)) begin
                len_b[i] <= wr_data;
            end
        end
        assign blk_len[8*i +: 8] = len_b[i];
    end

    // R9: a self-disable always leaves the enable clear on the next cycle
    a_r9_enable_cleared : assert property (@(posedge clk) disable iff (rst)
        en_clr |=> !ctrl.en);

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              step_en,
    input  step_e             dir,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int ADDR_BYTES = ADDR_W / 8;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a, input step_e d);
        logic [ADDR_W-1:0] n;
        unique case (d)
            STEP_UP:   n = a + ADDR_W'(1);
            STEP_DOWN: n = a - ADDR_W'(1);
            default:   n = a;
        endcase
        return n;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (step_en) begin
            cur_addr <= next_addr(cur_addr, dir);
        end else if (wr_ok) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (is_offset(wr_addr, int'(OFS_ADR0) + i)) begin
                    cur_addr[8*i +: 8] <= wr_data;
                end
            end
        end
    end

    // R5: stepping up advances the address by exactly one
    a_r5_step_up : assert property (@(posedge clk) disable iff (rst)
        (step_en && dir == STEP_UP) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    // R5: stepping down lowers the address by exactly one
    a_r5_step_down : assert property (@(posedge clk) disable iff (rst)
        (step_en && dir == STEP_DOWN) |=> cur_addr == $past(cur_addr) - ADDR_W'(1));

endmodule

// File: rtl/dma_blk_ctl.sv
module dma_blk_ctl
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RPT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              ch_en,
    input  logic              rpt_mode,
    input  logic [CNT_W-1:0]  blk_len,
    input  logic              req_ready,
    input  logic              wr_ok,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              abort_req,
    output logic              busy,
    output logic              start,
    output logic              xfer,
    output logic              en_clr,
    output logic              done
);
    seq_e             st;
    logic [CNT_W-1:0] left;
    logic [RPT_W-1:0] rpt;
    logic             abort_pend;
    logic             blk_end;
    logic             stop;
    logic             aborting;
    logic             rpt_last;

    assign busy     = (st == SEQ_RUN);
    assign start    = !busy && ch_en && trig;
    assign xfer     = busy && req_ready;
    assign blk_end  = xfer && (left == CNT_W'(1));
    assign aborting = abort_pend || abort_req;
    assign stop     = xfer && (blk_end || aborting);
    assign rpt_last = (rpt == RPT_W'(1));
    assign en_clr   = stop && (aborting || !rpt_mode || rpt_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SEQ_IDLE;
        end else if (start) begin
            st <= SEQ_RUN;
        end else if (stop) begin
            st <= SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= CNT_W'(1);
        end else if (start) begin
            left <= (blk_len == '0) ? '1 : blk_len;
        end else if (xfer) begin
            left <= left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt <= '0;
        end else if (wr_ok && wr_addr == OFS_RPT) begin
            rpt <= RPT_W'(wr_data);
        end else if (blk_end && rpt != '0) begin
            rpt <= rpt - RPT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_pend <= 1'b0;
        end else if (stop) begin
            abort_pend <= 1'b0;
        end else if (abort_req) begin
            abort_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else begin
            done <= en_clr;
        end
    end

    // R9: the done pulse never lasts two cycles
    a_r9_done_single : assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a running block always has elements left
    a_r6_left_nonzero : assert property (@(posedge clk) disable iff (rst)
        busy |-> left != '0);

    // R11: a pending abort ends the block at the next handshake
    a_r11_abort_ends : assert property (@(posedge clk) disable iff (rst)
        (abort_pend && req_ready) |=> !busy);

    // R3: no block starts while the channel is disabled
    a_r3_idle_without_enable : assert property (@(posedge clk) disable iff (rst)
        (!busy && !ch_en) |=> !busy);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RPT_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              trig,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              enabled,
    output logic              done
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] blk_len;
    logic             busy;
    logic             start;
    logic             xfer;
    logic             en_clr;
    logic             wr_ok;
    logic             abort_req;

    // Writes land only while idle and not starting; a clearing control write aborts a run
    assign wr_ok     = wr_en && !busy && !start;
    assign abort_req = wr_en && busy && (wr_addr == OFS_CTRL) && !wr_data[0];

    dma_cfg_regs #(.CNT_W(CNT_W)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_clr  (en_clr),
        .ctrl    (ctrl),
        .blk_len (blk_len)
    );

    dma_addr_unit #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .step_en  (xfer),
        .dir      (ctrl.dir),
        .cur_addr (req_addr)
    );

    dma_blk_ctl #(.CNT_W(CNT_W), .RPT_W(RPT_W)) i_ctl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .ch_en     (ctrl.en),
        .rpt_mode  (ctrl.rpt_mode),
        .blk_len   (blk_len),
        .req_ready (req_ready),
        .wr_ok     (wr_ok),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .abort_req (abort_req),
        .busy      (busy),
        .start     (start),
        .xfer      (xfer),
        .en_clr    (en_clr),
        .done      (done)
    );

    assign req_valid = busy;
    assign enabled   = ctrl.en;

    // R4: a waiting request keeps its address and stays valid
    a_r4_hold_request : assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R9: done only appears with the channel already disabled
    a_r9_done_disabled : assert property (@(posedge clk) disable iff (rst)
        done |-> !enabled);

    // R10: the address does not move while the channel is idle and unwritten
    a_r10_idle_addr_hold : assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !wr_en) |=> $stable(req_addr));

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        trig = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [23:0] req_addr;
    logic        enabled;
    logic        done;

    int nchk = 0;
    int nerr = 0;

    logic [23:0] exp_addr;
    logic [1:0]  cur_dir;

    always #2 clk = ~clk;

    dma_chan_seq i_dma_chan_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .trig      (trig),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .enabled   (enabled),
        .done      (done)
    );

    function automatic logic [23:0] step_fn(input logic [23:0] a, input logic [1:0] d);
        if (d == 2'b01) return a + 24'd1;
        if (d == 2'b10) return a - 24'd1;
        return a;
    endfunction

    function automatic logic [7:0] ctrl_byte(input bit en, input bit rpt, input logic [1:0] d);
        return {4'b0, d, rpt, en};
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: program the channel through the offset map
    task automatic setup(input logic [15:0] len, input logic [23:0] adr, input logic [7:0] rpt,
                         input bit rmode, input logic [1:0] d);
        wreg(3'd1, len[7:0]);
        wreg(3'd2, len[15:8]);
        wreg(3'd3, rpt);
        wreg(3'd4, adr[7:0]);
        wreg(3'd5, adr[15:8]);
        wreg(3'd6, adr[23:16]);
        wreg(3'd0, ctrl_byte(1'b1, rmode, d));
        exp_addr = adr;
        cur_dir  = d;
    endtask

    task automatic run_block(input int n, input int abort_at, input int junk_at,
                             input logic [2:0] jaddr, input bit dis, input bit fast,
                             input bit notrig, input string tag);
        int  k = 0;
        int  bad = 0;
        bit  sent = 0;
        bit  jsent = 0;
        bit  lost = 0;
        if (!notrig) begin
            @(negedge clk); trig = 1'b1;
            @(negedge clk); trig = 1'b0;
        end
        while (k < n) begin
            req_ready = fast ? 1'b1 : (($urandom % 4) != 0);
            wr_en = 1'b0;
            if (abort_at >= 0 && k >= abort_at && !sent) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00; sent = 1;
            end else if (junk_at >= 0 && k == junk_at && !jsent) begin
                wr_en = 1'b1; wr_addr = jaddr; wr_data = 8'h5A; jsent = 1;
            end
            #1;
            if (!req_valid) begin
                lost = 1;
                break;
            end
            if (req_ready) begin
                if (req_addr !== exp_addr) bad++;
                exp_addr = step_fn(exp_addr, cur_dir);
                k++;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        req_ready = 1'b0;
        #1;
        chk(!lost, {tag, " R4 request present for every element"}, k, n);
        chk(bad == 0, {tag, " R4 R5 element addresses"}, bad, 0);
        chk(!req_valid, {tag, " R6 block ends after its length"}, req_valid, 0);
        chk(done == dis, {tag, " R9 done at block end"}, done, dis);
        chk(enabled == !dis, {tag, " R9 enable after block"}, enabled, !dis);
        @(negedge clk); #1;
        chk(!done, {tag, " R9 done lasts one cycle"}, done, 0);
    endtask

    task automatic idle_trigger(input string tag);
        bit seen = 0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (req_valid) seen = 1;
            @(negedge clk);
        end
        chk(!seen, {tag, " R3 trigger ignored while disabled"}, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!enabled, "R1 enabled after reset", enabled, 0);
        chk(!req_valid, "R1 req_valid after reset", req_valid, 0);
        chk(!done, "R1 done after reset", done, 0);
        chk(req_addr == 24'h0, "R1 address after reset", req_addr, 0);

        // R1 default length of one, default address zero, counting up
        wreg(3'd0, ctrl_byte(1'b1, 1'b0, 2'b01));
        exp_addr = 24'h0; cur_dir = 2'b01;
        run_block(1, -1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R1 R7");
        idle_trigger("R3");

        // R5 wrap corners
        setup(16'd3, 24'h000000, 8'd0, 1'b0, 2'b10);
        run_block(3, -1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R5 down wrap");
        setup(16'd3, 24'hFFFFFF, 8'd0, 1'b0, 2'b01);
        run_block(3, -1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R5 up wrap");

        // R5 R6 R7 random single blocks, repeat mode off
        for (int it = 0; it < 16; it++) begin
            logic [15:0] len;
            logic [23:0] adr;
            logic [1:0]  d;
            logic [7:0]  rp;
            len = 16'(1 + ($urandom % 6));
            adr = 24'($urandom);
            d   = 2'($urandom);
            rp  = 8'($urandom % 4);
            setup(len, adr, rp, 1'b0, d);
            run_block(int'(len), -1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R5 R6 R7 random");
        end

        // R6 zero length gives the longest block
        setup(16'd0, 24'hFFFF00, 8'd0, 1'b0, 2'b01);
        run_block(65535, -1, -1, 3'd0, 1'b1, 1'b1, 1'b0, "R6 zero length");

        // R8 finite repeat of three, R10 length write mid-block ignored
        setup(16'd2, 24'h000001, 8'd3, 1'b1, 2'b10);
        run_block(2, -1, -1, 3'd0, 1'b0, 1'b0, 1'b0, "R8 block 1");
        run_block(2, -1, 0, 3'd2, 1'b0, 1'b0, 1'b0, "R8 R10 block 2");
        run_block(2, -1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R8 block 3");
        idle_trigger("R8");

        // R8 unlimited repeat, R10 address write mid-block ignored, R11 mid-block abort
        setup(16'd3, 24'h123456, 8'd0, 1'b1, 2'b01);
        for (int b = 0; b < 4; b++) begin
            run_block(3, -1, (b == 1) ? 1 : -1, 3'd4, 1'b0, 1'b0, 1'b0, "R8 unlimited");
        end
        run_block(2, 1, -1, 3'd0, 1'b1, 1'b0, 1'b0, "R11 abort mid-block");

        // R11 abort in the same cycle as the final element of a repeating block
        setup(16'd3, 24'h00AA00, 8'd0, 1'b1, 2'b11);
        run_block(3, 2, -1, 3'd0, 1'b1, 1'b1, 1'b0, "R11 abort on last element");

        // R10 length write in the trigger cycle is ignored
        setup(16'd2, 24'h000100, 8'd0, 1'b0, 2'b01);
        @(negedge clk);
        trig = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd5;
        @(negedge clk);
        trig = 1'b0; wr_en = 1'b0;
        run_block(2, -1, -1, 3'd0, 1'b1, 1'b0, 1'b1, "R10 write with trigger");
        // R3 trigger while busy is ignored: second trigger mid-block does not extend it
        setup(16'd4, 24'h000200, 8'd0, 1'b0, 2'b01);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        run_block(4, -1, -1, 3'd0, 1'b1, 1'b0, 1'b1, "R3 trigger while busy");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule